// File: doc/BRIEF.md
# OTP Packet Index Builder

This block walks a packetized one-time-programmable memory after reset and records where each packet starts. Every packet begins with a one-word header whose size field gives the payload length S. The next header sits S+2 words further on. The block reads the headers one after another from word offset 0. It gives each packet it finds the next free ID, starting at 0, and stores that packet's header offset in an index table. It also keeps a running byte total of the memory in use.

The scan ends at the first header whose size field is zero. It also ends once the byte total reaches the memory limit, or when a packet arrives after the table is already full. When the scan ends, a sticky done flag rises.

After that, any client can give a packet number on the lookup port and get back, in the same cycle, that packet's header offset and a valid flag. The client never has to know the variable packet sizes.

Memory reads use a simple request/acknowledge pair. The block holds a request and an address until the memory returns one acknowledge pulse carrying the header word.

Top module: `otp_pkt_index`

## Requirements
- R1: The first header request after reset is at word offset 0. Each later request is at the offset of the previous header plus S+2, where S is that header's size field.
- R2: Only header bits 15:8 form the size field S; all other header bits are ignored. A header with S equal to zero ends the scan and adds no packet.
- R3: Packets get consecutive IDs from 0 in the order they are found, and the table entry for an ID holds that packet's header offset.
- R4: For each packet added, the byte total grows by 4×(S+1).
- R5: The scan stops after a packet that brings the byte total to 11264 or more. That packet is still counted, and no further header is read.
- R6: The table holds 64 entries. If a 65th non-empty header is read, the scan stops, the overflow flag is set, and the packet count stays at 64.
- R7: `scan_done` rises when the scan ends and stays high until the next reset. While it is high, no memory request is made and the count and total stay frozen.
- R8: A lookup is valid only when `scan_done` is high and `lkp_id` is below the packet count. Its offset appears combinationally in the same cycle. An invalid lookup returns offset 0.
- R9: During reset, `scan_done`, `idx_overflow`, `pkt_count` and `byte_total` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; a new scan starts when it is released |
| mem_rd_req | output | 1 | Header read request, held until acknowledged |
| mem_rd_addr | output | 16 | Word offset of the header being read |
| mem_rd_ack | input | 1 | One-cycle pulse: `mem_rd_data` is valid |
| mem_rd_data | input | 32 | Header word returned by the memory |
| scan_done | output | 1 | Scan finished (sticky until reset) |
| idx_overflow | output | 1 | More packets were present than the table can hold |
| pkt_count | output | 7 | Number of packets indexed |
| byte_total | output | 15 | Bytes accounted for by the indexed packets |
| lkp_id | input | 7 | Packet ID to look up |
| lkp_valid | output | 1 | Lookup hit |
| lkp_offset | output | 16 | Header word offset of the packet looked up |

## Verification
The in-RTL assertions are checked on every cycle. They cover:
- the done flag stays high once set, and no request is issued after it;
- the packet count never exceeds the table depth, and overflow only appears with a full table;
- each table write is followed by a count increment of exactly one;
- the byte total never falls during a scan.

Some behaviour only the bench scenarios can show:
- the actual chain of offsets, and that only the size field is decoded;
- the exact byte total at the 11264-byte limit;
- termination at an empty header in the middle of memory;
- the 64-entry overflow;
- the full set of lookup results, including rejected IDs before and after the scan.

// File: rtl/otp_idx_pkg.sv
`timescale 1ns/1ps
package otp_idx_pkg;
   typedef enum logic [0:0] {
      SCAN_RD  = 1'b0,
      SCAN_END = 1'b1
   } scan_st_e;
endpackage

// File: rtl/otp_idx_table.sv
`timescale 1ns/1ps
module otp_idx_table #(
   parameter int DEPTH          = 64,
   parameter int ADDR_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int ID_W          = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ID_W-1:0]   wr_idx,
   input  logic [ADDR_W-1:0] wr_off,
   input  logic [ID_W-1:0]   rd_idx,
   output logic [ADDR_W-1:0] rd_off
);
   logic [ADDR_W-1:0] ent [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [ADDR_W-1:0] q;
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (wr_en && wr_idx == ID_W'(g))    q <= wr_off;
         end
      end else begin : g_noclr
         wire unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (wr_en && wr_idx == ID_W'(g))         q <= wr_off;
         end
      end
      assign ent[g] = q;
   end

   always_comb begin
      if (int'(rd_idx) < DEPTH) rd_off = ent[rd_idx];
      else                      rd_off = '0;
   end
endmodule

// File: rtl/otp_idx_scan.sv
`timescale 1ns/1ps
module otp_idx_scan
   import otp_idx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 16,
   parameter int SIZE_LSB  = 8,
   parameter int SIZE_W    = 8,
   parameter int MAX_PKTS  = 64,
   parameter int MEM_BYTES = 11264,
   localparam int ID_W     = $clog2(MAX_PKTS),
   localparam int CNT_W    = $clog2(MAX_PKTS + 1),
   localparam int BYTE_W   = $clog2(MEM_BYTES + 4 * (2 ** SIZE_W)) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              tbl_we,
   output logic [ID_W-1:0]   tbl_idx,
   output logic [ADDR_W-1:0] tbl_off,
   output logic [CNT_W-1:0]  pkt_count,
   output logic [BYTE_W-1:0] byte_total,
   output logic              done,
   output logic              overflow
);
   localparam logic [CNT_W-1:0]  CNT_FULL  = CNT_W'(MAX_PKTS);
   localparam logic [BYTE_W-1:0] BYTE_LIM  = BYTE_W'(MEM_BYTES);

   scan_st_e          st;
   logic [ADDR_W-1:0] cur_off;
   logic [SIZE_W-1:0] hdr_size;
   logic              hdr_empty, tbl_full;
   logic [BYTE_W-1:0] bytes_nxt;
   logic [ADDR_W-1:0] off_nxt;

   wire unused_hdr = ^{rd_data[DATA_W-1:SIZE_LSB+SIZE_W], rd_data[SIZE_LSB-1:0]};

   assign hdr_size  = rd_data[SIZE_LSB +: SIZE_W];
   assign hdr_empty = (hdr_size == '0);
   assign tbl_full  = (pkt_count == CNT_FULL);
   assign bytes_nxt = byte_total + BYTE_W'({({1'b0, hdr_size} + 1'b1), 2'b00});
   assign off_nxt   = cur_off + ADDR_W'(hdr_size) + ADDR_W'(2);

   assign rd_req  = (st == SCAN_RD);
   assign rd_addr = cur_off;
   assign done    = (st == SCAN_END);
   assign tbl_we  = rd_req && rd_ack && !hdr_empty && !tbl_full;
   assign tbl_idx = pkt_count[ID_W-1:0];
   assign tbl_off = cur_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SCAN_RD;
         cur_off    <= '0;
         pkt_count  <= '0;
         byte_total <= '0;
         overflow   <= 1'b0;
      end else if (st == SCAN_RD && rd_ack) begin
         if (hdr_empty) begin
            st <= SCAN_END;
         end else if (tbl_full) begin
            overflow <= 1'b1;
            st       <= SCAN_END;
         end else begin
            pkt_count  <= pkt_count + 1'b1;
            byte_total <= bytes_nxt;
            cur_off    <= off_nxt;
            if (bytes_nxt >= BYTE_LIM) st <= SCAN_END;
         end
      end
   end

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R7
   AST_NO_REQ_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !rd_req); // R7
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) pkt_count <= CNT_FULL); // R6
   AST_OVF_FULL:    assert property (@(posedge clk) disable iff (!rst_n) overflow |-> (pkt_count == CNT_FULL && done)); // R6
   AST_WRITE_STEP:  assert property (@(posedge clk) disable iff (!rst_n) tbl_we |=> pkt_count == $past(pkt_count) + 1'b1); // R3
   AST_BYTES_GROW:  assert property (@(posedge clk) disable iff (!rst_n) !done |=> byte_total >= $past(byte_total)); // R4
endmodule

// File: rtl/otp_idx_lookup.sv
`timescale 1ns/1ps
module otp_idx_lookup #(
   parameter int MAX_PKTS = 64,
   parameter int ADDR_W   = 16,
   localparam int ID_W    = $clog2(MAX_PKTS),
   localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
   input  logic              done,
   input  logic [CNT_W-1:0]  pkt_count,
   input  logic [CNT_W-1:0]  lkp_id,
   output logic [ID_W-1:0]   rd_idx,
   input  logic [ADDR_W-1:0] rd_off,
   output logic              lkp_valid,
   output logic [ADDR_W-1:0] lkp_offset
);
   assign rd_idx     = lkp_id[ID_W-1:0];
   assign lkp_valid  = done && (lkp_id < pkt_count);
   assign lkp_offset = lkp_valid ? rd_off : '0;
endmodule

// File: rtl/otp_pkt_index.sv
`timescale 1ns/1ps
module otp_pkt_index #(
   parameter int DATA_W         = 32,
   parameter int ADDR_W         = 16,
   parameter int SIZE_LSB       = 8,
   parameter int SIZE_W         = 8,
   parameter int MAX_PKTS       = 64,
   parameter int MEM_BYTES      = 11264,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int ID_W          = $clog2(MAX_PKTS),
   localparam int CNT_W         = $clog2(MAX_PKTS + 1),
   localparam int BYTE_W        = $clog2(MEM_BYTES + 4 * (2 ** SIZE_W)) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              scan_done,
   output logic              idx_overflow,
   output logic [CNT_W-1:0]  pkt_count,
   output logic [BYTE_W-1:0] byte_total,
   input  logic [CNT_W-1:0]  lkp_id,
   output logic              lkp_valid,
   output logic [ADDR_W-1:0] lkp_offset
);
   if (MAX_PKTS < 2) begin : g_bad_depth
      $error("MAX_PKTS must be at least 2");
   end
   if (SIZE_LSB < 1 || SIZE_LSB + SIZE_W >= DATA_W) begin : g_bad_field
      $error("size field must lie strictly inside the header word");
   end
   if (MEM_BYTES < 8) begin : g_bad_limit
      $error("MEM_BYTES too small");
   end

   logic              tbl_we;
   logic [ID_W-1:0]   tbl_idx, rd_idx;
   logic [ADDR_W-1:0] tbl_off, rd_off;

   otp_idx_scan #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_LSB(SIZE_LSB), .SIZE_W(SIZE_W),
      .MAX_PKTS(MAX_PKTS), .MEM_BYTES(MEM_BYTES)
   ) u_scan (
      .clk(clk), .rst_n(rst_n),
      .rd_req(mem_rd_req), .rd_addr(mem_rd_addr),
      .rd_ack(mem_rd_ack), .rd_data(mem_rd_data),
      .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_off(tbl_off),
      .pkt_count(pkt_count), .byte_total(byte_total),
      .done(scan_done), .overflow(idx_overflow)
   );

   otp_idx_table #(
      .DEPTH(MAX_PKTS), .ADDR_W(ADDR_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_off(tbl_off),
      .rd_idx(rd_idx), .rd_off(rd_off)
   );

   otp_idx_lookup #(
      .MAX_PKTS(MAX_PKTS), .ADDR_W(ADDR_W)
   ) u_lookup (
      .done(scan_done), .pkt_count(pkt_count), .lkp_id(lkp_id),
      .rd_idx(rd_idx), .rd_off(rd_off),
      .lkp_valid(lkp_valid), .lkp_offset(lkp_offset)
   );
endmodule

// File: tb/otp_pkt_index_tb.sv
`timescale 1ns/1ps
module otp_pkt_index_tb_top;
   localparam int MEMW  = 3072;
   localparam int LIMIT = 11264;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_req, rd_ack, done, ovf, lkp_valid;
   logic [15:0] rd_addr, lkp_offset;
   logic [31:0] rd_data;
   logic [6:0]  pkt_count, lkp_id;
   logic [14:0] byte_total;

   always #5 clk = ~clk;

   otp_pkt_index dut_i (
      .clk(clk), .rst_n(rst_n),
      .mem_rd_req(rd_req), .mem_rd_addr(rd_addr),
      .mem_rd_ack(rd_ack), .mem_rd_data(rd_data),
      .scan_done(done), .idx_overflow(ovf),
      .pkt_count(pkt_count), .byte_total(byte_total),
      .lkp_id(lkp_id), .lkp_valid(lkp_valid), .lkp_offset(lkp_offset)
   );

   logic [31:0] mem [MEMW];

   always @(posedge clk) begin
      if (!rst_n) begin
         rd_ack  <= 1'b0;
         rd_data <= '0;
      end else if (rd_req && !rd_ack) begin
         rd_ack  <= 1'b1;
         rd_data <= (int'(rd_addr) < MEMW) ? mem[rd_addr] : 32'h0;
      end else begin
         rd_ack  <= 1'b0;
      end
   end

   int checks = 0, errors = 0;
   int exp_off [80];
   int exp_cnt, exp_bytes, wp;
   bit exp_ovf, model_stop;

   // Packet size vectors for the first scenario; the zero ends the chain.
   localparam int NV = 6;
   localparam int VEC_SZ [NV] = '{3, 1, 5, 200, 0, 7};
   // Lookup vectors: id, expected valid, expected offset.
   localparam int NL = 6;
   localparam int LK_ID  [NL] = '{0, 1, 2, 3, 4, 70};
   localparam int LK_VAL [NL] = '{1, 1, 1, 1, 0, 0};
   localparam int LK_OFF [NL] = '{0, 5, 8, 15, 0, 0};

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < MEMW; i++) mem[i] = 32'h0;
      wp = 0; exp_cnt = 0; exp_bytes = 0; exp_ovf = 0; model_stop = 0;
   endtask

   task automatic add_pkt(input int sz);
      logic [7:0] s8;
      s8 = sz[7:0];
      mem[wp] = {16'hC35A, s8, 8'h96};
      for (int i = 1; i <= sz; i++) if (wp + i < MEMW) mem[wp + i] = 32'hFFFF_FFFF;
      if (!model_stop) begin
         if (sz == 0) model_stop = 1;
         else if (exp_cnt == 64) begin exp_ovf = 1; model_stop = 1; end
         else begin
            exp_off[exp_cnt] = wp;
            exp_cnt++;
            exp_bytes += 4 * (sz + 1);
            if (exp_bytes >= LIMIT) model_stop = 1;
         end
      end
      wp += sz + 2;
   endtask

   task automatic look(input int id, output bit v, output int off);
      lkp_id = 7'(id);
      #1;
      v = lkp_valid;
      off = int'(lkp_offset);
   endtask

   task automatic run_scan();
      bit v; int off; int n;
      rst_n = 1'b0;
      lkp_id = '0;
      repeat (3) @(negedge clk);
      chk(done == 0 && ovf == 0, "R9 reset flags", {done, ovf}, 0);
      chk(pkt_count == 0 && byte_total == 0, "R9 reset count/total", pkt_count + byte_total, 0);
      chk(rd_addr == 0, "R1 first request offset", rd_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      look(0, v, off);
      chk(done == 0 && v == 0, "R8 lookup before done invalid", v, 0);
      n = 0;
      while (!done && n < 20000) begin @(negedge clk); n++; end
      chk(done == 1, "R7 scan reaches done", done, 1);
      chk(int'(pkt_count) == exp_cnt, "R3 packet count", pkt_count, exp_cnt);
      chk(int'(byte_total) == exp_bytes, "R4 byte total", byte_total, exp_bytes);
      chk(ovf == exp_ovf, "R6 overflow flag", ovf, exp_ovf);
      for (int id = 0; id <= exp_cnt + 1 && id < 128; id++) begin
         look(id, v, off);
         if (id < exp_cnt) begin
            chk(v == 1, "R8 lookup valid", v, 1);
            chk(off == exp_off[id], "R3 lookup offset", off, exp_off[id]);
         end else begin
            chk(v == 0 && off == 0, "R8 lookup beyond count rejected", {v, off[15:0]}, 0);
         end
      end
      repeat (10) @(negedge clk);
      chk(done == 1 && rd_req == 0, "R7 done sticky, no request", {done, rd_req}, 2);
      chk(int'(pkt_count) == exp_cnt && int'(byte_total) == exp_bytes, "R7 frozen results",
          pkt_count, exp_cnt);
   endtask

   initial begin
      bit v; int off;
      // Scenario A: vector chain with an empty header in the middle (R1 R2 R3 R4)
      clear_mem();
      for (int i = 0; i < NV; i++) add_pkt(VEC_SZ[i]);
      run_scan();
      chk(int'(pkt_count) == 4, "R2 zero size stops scan", pkt_count, 4);
      for (int i = 0; i < NL; i++) begin
         look(LK_ID[i], v, off);
         chk(int'(v) == LK_VAL[i] && off == LK_OFF[i], "R8 lookup vector", off, LK_OFF[i]);
      end

      // Scenario B: memory starts with an empty header
      clear_mem();
      add_pkt(0);
      run_scan();
      chk(pkt_count == 0 && byte_total == 0, "R2 empty memory", pkt_count, 0);

      // Scenario C: byte limit, 11 packets of 1024 bytes reach 11264
      clear_mem();
      for (int i = 0; i < 12; i++) add_pkt(255);
      run_scan();
      chk(int'(pkt_count) == 11 && int'(byte_total) == LIMIT, "R5 byte limit stop",
          byte_total, LIMIT);

      // Scenario D: 66 small packets overflow the 64-entry table
      clear_mem();
      for (int i = 0; i < 66; i++) add_pkt(1);
      run_scan();
      chk(int'(pkt_count) == 64 && ovf == 1, "R6 table overflow", pkt_count, 64);
      look(63, v, off);
      chk(v == 1 && off == 189, "R6 last entry offset", off, 189);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule